// File: doc/BRIEF.md
# Over-Temperature Alert Output Controller

This block sets the state of a single over-temperature alert pin. A temperature converter elsewhere pulses a conversion-done strobe with a fresh 11-bit two's complement reading (0.125 °C per LSB). On each strobe the block compares that reading with a 9-bit signed trip limit and a 9-bit signed hysteresis limit (0.5 °C per LSB). Only after a programmed number of consecutive faulting conversions does it change the alert. It drives an open-drain pin through a pull-down enable.

Two behaviours are selectable. As a thermostat, the alert turns on above the trip limit and turns off below the hysteresis limit. Reads and shutdown leave it alone. In latched interrupt mode, the alert fires once and holds until any register read. The condition that can fire it alternates between rising above the trip limit and falling below the hysteresis limit. Entering shutdown in this mode drops the alert. The register file that owns the limits and configuration bits is outside this block. The package supplies the power-on limit values it should load: 80 °C as 9-bit 0x0A0 for the trip limit and 75 °C as 0x096 for the hysteresis limit.

Top module: `thermal_alert`

## Requirements
- R1: After reset the alert is inactive, the fault count is zero and the interrupt condition is armed on the trip limit.
- R2: A reading faults high when its 9 upper bits, taken as signed, are strictly greater than the trip limit. It faults low when they are strictly less than the hysteresis limit. Bit 10 is the sign bit, and a negative reading floors toward minus infinity.
- R3: With `int_mode`=0, the alert turns on when a conversion completes the fault streak above the trip limit. It turns off at the first conversion below the hysteresis limit. Between conversions it does not change.
- R4: With `int_mode`=0, a pulse on `reg_rd` and a high `shutdown` leave the alert unchanged.
- R5: With `int_mode`=1, after reset or a mode change the alert can fire only on a high fault. It then holds through any later conversion until `reg_rd` is pulsed with `shutdown` low.
- R6: With `int_mode`=1, each firing swaps the armed condition, so firings alternate between a high fault and a low fault.
- R7: While `shutdown` is 1, conversion strobes are ignored in both modes. In interrupt mode a high `shutdown` clears the alert and the fault count.
- R8: `fq_code` selects the run of consecutive faulting conversions needed to fire: 00 needs 1, 01 needs 2, 10 needs 4 and 11 needs 6.
- R9: The fault count returns to zero on any accepted conversion that does not meet the armed condition, when the alert fires, and when a read clears the interrupt.
- R10: `pd_en` is 1 exactly when the pin must be low. With `pol_high`=0 that is while the alert is active. With `pol_high`=1 it is while the alert is inactive.
- R11: A change of `int_mode` returns the alert to inactive, re-arms on the trip limit and zeroes the count. A conversion strobe in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: `temp_code` holds a new reading |
| temp_code | input | 11 | Temperature, two's complement, 0.125 °C per LSB |
| trip_lim | input | 9 | Trip limit, two's complement, 0.5 °C per LSB |
| hyst_lim | input | 9 | Hysteresis limit, two's complement, 0.5 °C per LSB |
| int_mode | input | 1 | 0 thermostat mode, 1 latched interrupt mode |
| pol_high | input | 1 | 0 alert active low, 1 alert active high |
| fq_code | input | 2 | Consecutive-fault depth code |
| shutdown | input | 1 | Conversion halted |
| reg_rd | input | 1 | One-cycle pulse for any register read |
| pd_en | output | 1 | Enable for the open-drain pull-down on the alert pin |

## Verification
The assertions assume that `conv_done` and `reg_rd` are single-cycle pulses. They also assume the configuration inputs change only between strobes and that the trip limit sits above the hysteresis limit. If the limits were inverted, the thermostat could fault high and low on the same reading. The stimulus changes configuration only in idle cycles with no strobe. It always places the trip limit above the hysteresis limit, including in the negative-temperature case. It never changes the depth code in the middle of a fault streak, so the count stays within the deepest queue.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

  localparam int TEMP_W    = 11;
  localparam int LIM_W     = 9;
  localparam int FQ_W      = 2;
  localparam int CNT_W     = 3;
  localparam int MAX_DEPTH = 6;

  // power-on limit values for the register file that feeds this block
  localparam logic [LIM_W-1:0] TRIP_RST = 9'h0A0;  // 80.0 C
  localparam logic [LIM_W-1:0] HYST_RST = 9'h096;  // 75.0 C

  typedef enum logic { MODE_CMP = 1'b0, MODE_INT = 1'b1 } alert_mode_e;
  typedef enum logic { ARM_TRIP = 1'b0, ARM_HYST = 1'b1 } arm_e;

  // consecutive-fault depth selected by the queue code
  function automatic logic [CNT_W-1:0] fq_depth(input logic [FQ_W-1:0] code);
    case (code)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(4);
      default: return CNT_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/ta_limit_cmp.sv
module ta_limit_cmp #(
  parameter int T_W = 11,
  parameter int L_W = 9
) (
  input  logic [T_W-1:0] temp,
  input  logic [L_W-1:0] trip,
  input  logic [L_W-1:0] hyst,
  output logic           over,
  output logic           under
);
  localparam int DROP = T_W - L_W;

  // upper bits of temp > lim  <=>  temp > lim with all dropped bits set
  function automatic logic above_lim(input logic [T_W-1:0] t, input logic [L_W-1:0] l);
    return $signed(t) > $signed({l, {DROP{1'b1}}});
  endfunction

  // upper bits of temp < lim  <=>  temp < lim with all dropped bits clear
  function automatic logic below_lim(input logic [T_W-1:0] t, input logic [L_W-1:0] l);
    return $signed(t) < $signed({l, {DROP{1'b0}}});
  endfunction

  assign over  = above_lim(temp, trip);
  assign under = below_lim(temp, hyst);
endmodule

// File: rtl/ta_fault_count.sv
module ta_fault_count
  import thermal_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic             fault,
  input  logic [FQ_W-1:0]  fq_code,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W:0]   cnt_nx;
  logic [CNT_W-1:0] need;

  assign need   = fq_depth(fq_code);
  assign cnt_nx = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign hit    = sample & fault & (cnt_nx >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (sample) begin
      if (!fault || hit)             cnt <= '0;
      else                           cnt <= cnt_nx[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/ta_alert_state.sv
module ta_alert_state
  import thermal_alert_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        int_mode,
  input  logic        shutdown,
  input  logic        reg_rd,
  input  logic        conv_done,
  input  logic        over,
  input  logic        under,
  input  logic        hit,
  output logic        act_o,
  output arm_e        arm_o,
  output alert_mode_e mode_o,
  output logic        sample_o,
  output logic        fault_o,
  output logic        cnt_clr_o,
  output logic        fire_o
);
  logic mode_chg, conv_ok, rd_clr, sd_hit, rel_ev, is_int;

  assign is_int    = (mode_o == MODE_INT);
  assign mode_chg  = (alert_mode_e'(int_mode) != mode_o);
  assign conv_ok   = conv_done & ~shutdown & ~mode_chg;
  assign sample_o  = conv_ok & ~act_o;
  assign fault_o   = (is_int && arm_o == ARM_HYST) ? under : over;
  assign rel_ev    = conv_ok & act_o & ~is_int & under;
  assign sd_hit    = ~mode_chg & is_int & shutdown;
  assign rd_clr    = ~mode_chg & ~shutdown & is_int & act_o & reg_rd;
  assign fire_o    = hit;
  assign cnt_clr_o = mode_chg | sd_hit | rd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_o  <= 1'b0;
      arm_o  <= ARM_TRIP;
      mode_o <= MODE_CMP;
    end else if (mode_chg) begin
      act_o  <= 1'b0;
      arm_o  <= ARM_TRIP;
      mode_o <= alert_mode_e'(int_mode);
    end else if (sd_hit) begin
      act_o  <= 1'b0;
    end else if (fire_o) begin
      act_o  <= 1'b1;
      if (is_int) arm_o <= (arm_o == ARM_TRIP) ? ARM_HYST : ARM_TRIP;
    end else if (rel_ev || rd_clr) begin
      act_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/thermal_alert.sv
module thermal_alert
  import thermal_alert_pkg::*;
#(
  parameter int T_W = TEMP_W,
  parameter int L_W = LIM_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_done,
  input  logic [T_W-1:0] temp_code,
  input  logic [L_W-1:0] trip_lim,
  input  logic [L_W-1:0] hyst_lim,
  input  logic           int_mode,
  input  logic           pol_high,
  input  logic [1:0]     fq_code,
  input  logic           shutdown,
  input  logic           reg_rd,
  output logic           pd_en
);
  logic             over, under, hit;
  logic             alert_act, sample, fault, cnt_clr, ev_fire;
  arm_e             arm_q;
  alert_mode_e      mode_q;
  logic [CNT_W-1:0] fault_cnt;

  ta_limit_cmp #(.T_W(T_W), .L_W(L_W)) u_cmp (
    .temp (temp_code), .trip (trip_lim), .hyst (hyst_lim),
    .over (over), .under (under)
  );

  ta_fault_count u_cnt (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .sample (sample),
    .fault (fault), .fq_code (fq_code), .cnt (fault_cnt), .hit (hit)
  );

  ta_alert_state u_fsm (
    .clk (clk), .rst_n (rst_n), .int_mode (int_mode), .shutdown (shutdown),
    .reg_rd (reg_rd), .conv_done (conv_done), .over (over), .under (under),
    .hit (hit), .act_o (alert_act), .arm_o (arm_q), .mode_o (mode_q),
    .sample_o (sample), .fault_o (fault), .cnt_clr_o (cnt_clr), .fire_o (ev_fire)
  );

  // pin low = pull-down on; low means active only for active-low polarity
  assign pd_en = alert_act ^ pol_high;
endmodule

// File: rtl/thermal_alert_chk.sv
module thermal_alert_chk
  import thermal_alert_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             conv_done,
  input logic             reg_rd,
  input logic             shutdown,
  input logic             int_mode,
  input logic             alert_act,
  input logic             mode_q,
  input logic             arm_q,
  input logic [CNT_W-1:0] fault_cnt,
  input logic             ev_fire
);
  p_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!alert_act && fault_cnt == '0));

  p_fire_at_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_act) |-> $past(conv_done));

  p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_mode && !mode_q && !conv_done) |=> $stable(alert_act));

  p_int_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && mode_q && alert_act && !reg_rd && !shutdown) |=> alert_act);

  p_arm_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && int_mode && mode_q) |=> (arm_q != $past(arm_q)));

  p_sd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && shutdown) |=> (!alert_act && fault_cnt == '0));

  p_cnt_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cnt < CNT_W'(MAX_DEPTH));

  p_fire_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> (alert_act && fault_cnt == '0));

  p_mode_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode != mode_q) |=> (!alert_act && !arm_q && fault_cnt == '0));
endmodule

bind thermal_alert thermal_alert_chk u_chk (.*);

// File: tb/thermal_alert_bench.sv
module thermal_alert_bench;
  import thermal_alert_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_conv = 1'b0;
  logic [10:0] d_temp = '0;
  logic [8:0]  d_trip = TRIP_RST;
  logic [8:0]  d_hyst = HYST_RST;
  logic        d_int = 1'b0;
  logic        d_pol = 1'b0;
  logic [1:0]  d_fq = 2'b00;
  logic        d_sd = 1'b0;
  logic        d_rd = 1'b0;
  logic        pd_en;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_act = 0, m_arm = 0, m_cnt = 0, m_mode = 0;

  always #4 clk = ~clk;  // 125 MHz

  thermal_alert u_thermal_alert (
    .clk (clk), .rst_n (rst_n), .conv_done (d_conv), .temp_code (d_temp),
    .trip_lim (d_trip), .hyst_lim (d_hyst), .int_mode (d_int),
    .pol_high (d_pol), .fq_code (d_fq), .shutdown (d_sd), .reg_rd (d_rd),
    .pd_en (pd_en)
  );

  function automatic int sext9(input logic [8:0] v);
    return v[8] ? int'(v) - 512 : int'(v);
  endfunction

  // reading in 0.5 C steps, rounded toward minus infinity
  function automatic int half_deg(input logic [10:0] v);
    int e;
    e = v[10] ? int'(v) - 2048 : int'(v);
    if (e >= 0) return e / 4;
    return -((-e + 3) / 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_arm = 0; m_cnt = 0; m_mode = 0;
    end else if (int'(d_int) != m_mode) begin
      m_mode = int'(d_int); m_act = 0; m_arm = 0; m_cnt = 0;
    end else if (d_int && d_sd) begin
      m_act = 0; m_cnt = 0;
    end else if (m_act != 0) begin
      if (d_int) begin
        if (d_rd) begin m_act = 0; m_cnt = 0; end
      end else if (d_conv && !d_sd && half_deg(d_temp) < sext9(d_hyst)) begin
        m_act = 0;
      end
    end else if (d_conv && !d_sd) begin
      int  need;
      bit  hi, lo, f;
      need = (d_fq == 2'b00) ? 1 : 2 * int'(d_fq);
      hi = half_deg(d_temp) > sext9(d_trip);
      lo = half_deg(d_temp) < sext9(d_hyst);
      f  = (d_int && m_arm != 0) ? lo : hi;
      if (f) begin
        m_cnt++;
        if (m_cnt >= need) begin
          m_act = 1; m_cnt = 0;
          if (d_int) m_arm = 1 - m_arm;
        end
      end else begin
        m_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_pd;
      exp_pd = (m_act != 0) ^ d_pol;
      vectors++;
      if (pd_en !== exp_pd) begin
        fails++;
        $display("FAIL %s t=%0t pd_en=%b expected %b", cur_req, $time, pd_en, exp_pd);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic conv(input int e8);
    d_temp = 11'(e8);
    d_conv = 1'b1;
    tick();
    d_conv = 1'b0;
    tick();
  endtask

  task automatic rd();
    d_rd = 1'b1;
    tick();
    d_rd = 1'b0;
    tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    cur_req = "R1";  // reset state, inactive
    repeat (3) tick();

    cur_req = "R2";  // strict compare on upper bits: 80.0 and 80.375 do not trip
    conv(640); conv(643);
    cur_req = "R3";
    conv(644);                 // 80.5 trips
    conv(620); conv(600);      // 77.5 and 75.0 hold
    cur_req = "R2";
    conv(599);                 // 74.875 floors to 74.5, releases
    cur_req = "R3";
    repeat (4) tick();

    cur_req = "R4";            // reads and shutdown leave thermostat alone
    conv(700); rd(); d_sd = 1'b1; tick(); tick();
    cur_req = "R7";            // strobe ignored while shut down
    conv(500);
    d_sd = 1'b0; tick();
    cur_req = "R4";
    rd(); conv(500);

    cur_req = "R11";           // mode change drops the alert
    conv(700);
    d_int = 1'b1; d_temp = 11'(700); d_conv = 1'b1; tick(); d_conv = 1'b0; tick();

    cur_req = "R5";
    conv(500); conv(700); conv(500); conv(700);
    rd();
    cur_req = "R6";
    conv(700); conv(700); conv(500); rd(); conv(500); conv(700); rd();

    cur_req = "R7";            // armed on low fault; fire then shut down
    conv(500); d_sd = 1'b1; tick(); conv(700); d_sd = 1'b0; tick();
    conv(700); rd();

    cur_req = "R10";
    d_pol = 1'b1; tick();
    conv(500); tick(); rd(); d_pol = 1'b0; tick();

    cur_req = "R8";
    d_int = 1'b0; tick(); tick();
    for (int c = 0; c < 4; c++) begin
      int need;
      d_fq = 2'(c);
      tick();
      need = (c == 0) ? 1 : 2 * c;
      for (int k = 0; k < need; k++) conv(680);
      conv(500);
    end

    cur_req = "R9";            // broken streak restarts the count
    d_fq = 2'b10; tick();
    conv(680); conv(680); conv(680); conv(640);
    conv(680); conv(680); conv(680);
    conv(680); conv(500);
    d_int = 1'b1; d_fq = 2'b01; tick(); tick();
    conv(700); conv(640); conv(700); conv(700);
    rd(); conv(500); conv(700); conv(500); conv(500); rd();

    cur_req = "R2";            // negative limits: trip -10.0, hyst -20.0
    d_int = 1'b0; d_fq = 2'b00;
    d_trip = 9'(-20); d_hyst = 9'(-40); tick(); tick();
    conv(-81); conv(-76); conv(-150); conv(-160); conv(-161);
    conv(-76); conv(-164);

    cur_req = "R10";
    d_pol = 1'b1; tick(); conv(-60); tick(); conv(-200); d_pol = 1'b0; tick();

    repeat (4) tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule